// File: doc/BRIEF.md
# Combined Two-Dimensional Subband Scaler

This block is the final stage of a separable two-dimensional lifting wavelet transform whose row pass and column pass both leave out their own normalisation. It applies the two normalisations together as one merged factor per subband. Each coefficient arrives with two tag bits that give its parity in each direction. Coefficients that are low-pass in both directions are multiplied by k², and coefficients that are high-pass in both directions are multiplied by 1/k². Coefficients of the two mixed subbands need no factor, because the k and the 1/k cancel, so they pass through unchanged. Only half of the coefficients go through a multiplier, and only one multiply is done per scaled coefficient instead of two.

The block has two independent lanes, so it accepts and returns two coefficients every clock. Each lane registers its result once. Every coefficient, whether it is scaled or passed through, leaves exactly one cycle after it enters, together with its own tag bits. The gains are unsigned fixed-point constants with `FRAC_W` fractional bits: 21653 for k² ≈ 1.321590 and 12397 for 1/k² ≈ 0.756664 when `FRAC_W` is 14. The result is widened by one bit so that the k² gain cannot overflow.

Top module: `dwt_subband_scaler`

## Requirements
- R1: A coefficient tagged row_high=0, col_high=0 (low/low) leaves as round(x·21653/2^14) with the default parameters.
- R2: A coefficient tagged row_high=1, col_high=1 (high/high) leaves as round(x·12397/2^14) with the default parameters.
- R3: A coefficient tagged 01 or 10 (mixed subband) leaves unchanged, sign-extended to the output width.
- R4: out_valid of a lane is in_valid of that lane delayed by exactly one clock, for both the scaled and the pass-through paths.
- R5: The tag bits of an output are the tag bits that entered with that coefficient one cycle earlier.
- R6: The two lanes work independently in the same cycle. Lane n uses bits [n*DATA_W +: DATA_W] of in_data and bits [n*OUT_W +: OUT_W] of out_data.
- R7: While rst_n is low, out_valid, out_data and both tag outputs are zero.
- R8: Rounding is to nearest, and an exact half rounds toward plus infinity. For a low/low input, 8192 gives 10827 and -8192 gives -10826.
- R9: Every scaled output is within 1 LSB of the value obtained by multiplying by k or 1/k after the row pass and again after the column pass, with k = 1.149604.
- R10: In a cycle after in_valid of a lane was low, that lane's out_data and tags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | LANES | Per-lane input strobe |
| in_data | input | LANES*DATA_W | Signed input coefficients, lane 0 in the low bits |
| in_row_high | input | LANES | Tag: coefficient is high-pass along rows |
| in_col_high | input | LANES | Tag: coefficient is high-pass along columns |
| out_valid | output | LANES | Per-lane output strobe |
| out_data | output | LANES*OUT_W | Signed scaled coefficients, lane 0 in the low bits |
| out_row_high | output | LANES | Row tag aligned with out_data |
| out_col_high | output | LANES | Column tag aligned with out_data |

## Verification
The assertions check on every cycle that the timing and alignment hold. Each lane's strobe is delayed by one clock, the tags travel with the data, mixed-subband data comes out unaltered, and an idle lane holds its output. Only the bench scenarios can show that the arithmetic is right: the values of the two gains, rounding of exact halves, the largest positive and negative inputs, and agreement within one LSB with separate per-pass k and 1/k scaling. These are checked by comparing against a real-valued model of the subband gains.

// File: rtl/dwt_scl_pkg.sv
package dwt_scl_pkg;

    // Subband classes, decoded from {row_high, col_high}
    typedef enum logic [1:0] {
        BAND_LL = 2'b00,
        BAND_LH = 2'b01,
        BAND_HL = 2'b10,
        BAND_HH = 2'b11
    } band_e;

    // Gain path chosen for a coefficient
    typedef enum logic [1:0] {
        GAIN_PASS = 2'd0,
        GAIN_UP   = 2'd1,
        GAIN_DOWN = 2'd2
    } gain_e;

    localparam int unsigned DEF_FRAC_W = 14;
    // k^2 ~ 1.321590 and 1/k^2 ~ 0.756664 in Q(DEF_FRAC_W)
    localparam int unsigned DEF_GAIN_UP_Q   = 21653;
    localparam int unsigned DEF_GAIN_DOWN_Q = 12397;

endpackage

// File: rtl/dwt_scl_decode.sv
module dwt_scl_decode
    import dwt_scl_pkg::*;
(
    input  logic  row_high,
    input  logic  col_high,
    output band_e band,
    output gain_e gain_sel
);

    always_comb begin
        band = band_e'({row_high, col_high});
        unique case (band)
            BAND_LL: gain_sel = GAIN_UP;
            BAND_HH: gain_sel = GAIN_DOWN;
            BAND_LH,
            BAND_HL: gain_sel = GAIN_PASS;
            default: gain_sel = GAIN_PASS;
        endcase
    end

endmodule

// File: rtl/dwt_scl_lane.sv
module dwt_scl_lane
    import dwt_scl_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned FRAC_W      = DEF_FRAC_W,
    parameter int unsigned GAIN_UP_Q   = DEF_GAIN_UP_Q,
    parameter int unsigned GAIN_DOWN_Q = DEF_GAIN_DOWN_Q,
    localparam int unsigned OUT_W      = DATA_W + 1,
    localparam int unsigned GAIN_W     = FRAC_W + 1,
    localparam int unsigned PROD_W     = OUT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_row_high,
    input  logic              in_col_high,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    output logic              out_row_high,
    output logic              out_col_high
);

    band_e               band;
    gain_e               gain_sel;
    logic [GAIN_W-1:0]   gain_q;
    logic signed [PROD_W-1:0] data_x;
    logic signed [PROD_W-1:0] gain_x;
    logic signed [PROD_W-1:0] prod;
    logic [OUT_W-1:0]    trunc_v;
    logic                half_bit;
    logic [OUT_W-1:0]    scaled;
    logic [OUT_W-1:0]    passed;
    logic [OUT_W-1:0]    next_data;

    dwt_scl_decode i_decode (
        .row_high (in_row_high),
        .col_high (in_col_high),
        .band     (band),
        .gain_sel (gain_sel)
    );

    always_comb begin
        gain_q   = (gain_sel == GAIN_UP) ? GAIN_W'(GAIN_UP_Q) : GAIN_W'(GAIN_DOWN_Q);
        data_x   = {{(PROD_W-DATA_W){in_data[DATA_W-1]}}, in_data};
        gain_x   = {{(PROD_W-GAIN_W){1'b0}}, gain_q};
        prod     = data_x * gain_x;
        trunc_v  = prod[FRAC_W +: OUT_W];
        half_bit = prod[FRAC_W-1];
        scaled   = trunc_v + OUT_W'(half_bit);
        passed   = {{(OUT_W-DATA_W){in_data[DATA_W-1]}}, in_data};
        unique case (gain_sel)
            GAIN_UP,
            GAIN_DOWN: next_data = scaled;
            GAIN_PASS: next_data = passed;
            default:   next_data = passed;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_data     <= '0;
            out_row_high <= 1'b0;
            out_col_high <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data     <= next_data;
                out_row_high <= in_row_high;
                out_col_high <= in_col_high;
            end
        end
    end

    // R4
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R5
    tag_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |->
            (out_row_high == $past(in_row_high) && out_col_high == $past(in_col_high)));

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && ($past(in_row_high) != $past(in_col_high))) |->
            (out_data == {{(OUT_W-DATA_W){$past(in_data[DATA_W-1])}}, $past(in_data)}));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |->
            ($stable(out_data) && $stable(out_row_high) && $stable(out_col_high)));

endmodule

// File: rtl/dwt_subband_scaler.sv
module dwt_subband_scaler
    import dwt_scl_pkg::*;
#(
    parameter int unsigned LANES       = 2,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned FRAC_W      = DEF_FRAC_W,
    parameter int unsigned GAIN_UP_Q   = DEF_GAIN_UP_Q,
    parameter int unsigned GAIN_DOWN_Q = DEF_GAIN_DOWN_Q,
    localparam int unsigned OUT_W      = DATA_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        in_valid,
    input  logic [LANES*DATA_W-1:0] in_data,
    input  logic [LANES-1:0]        in_row_high,
    input  logic [LANES-1:0]        in_col_high,
    output logic [LANES-1:0]        out_valid,
    output logic [LANES*OUT_W-1:0]  out_data,
    output logic [LANES-1:0]        out_row_high,
    output logic [LANES-1:0]        out_col_high
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dwt_scl_lane #(
            .DATA_W      (DATA_W),
            .FRAC_W      (FRAC_W),
            .GAIN_UP_Q   (GAIN_UP_Q),
            .GAIN_DOWN_Q (GAIN_DOWN_Q)
        ) i_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .in_valid     (in_valid[g]),
            .in_data      (in_data[g*DATA_W +: DATA_W]),
            .in_row_high  (in_row_high[g]),
            .in_col_high  (in_col_high[g]),
            .out_valid    (out_valid[g]),
            .out_data     (out_data[g*OUT_W +: OUT_W]),
            .out_row_high (out_row_high[g]),
            .out_col_high (out_col_high[g])
        );
    end

    // R7
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (out_valid == '0 && out_data == '0));

endmodule

// File: tb/test_dwt_subband_scaler.sv
module test_dwt_subband_scaler;

    localparam int  LANES  = 2;
    localparam int  DATA_W = 16;
    localparam int  OUT_W  = DATA_W + 1;
    localparam time CLK_PERIOD = 10ns;
    localparam real K_REAL = 1.149604;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [LANES-1:0]        in_valid = '0;
    logic [LANES*DATA_W-1:0] in_data = '0;
    logic [LANES-1:0]        in_row_high = '0;
    logic [LANES-1:0]        in_col_high = '0;
    logic [LANES-1:0]        out_valid;
    logic [LANES*OUT_W-1:0]  out_data;
    logic [LANES-1:0]        out_row_high;
    logic [LANES-1:0]        out_col_high;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // reference model state, per lane
    int exp_valid [LANES];
    int exp_data  [LANES];
    int exp_rh    [LANES];
    int exp_ch    [LANES];
    real sep_ref  [LANES];

    always #(CLK_PERIOD/2) clk = ~clk;

    dwt_subband_scaler i_dwt_subband_scaler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_row_high(in_row_high), .in_col_high(in_col_high),
        .out_valid(out_valid), .out_data(out_data),
        .out_row_high(out_row_high), .out_col_high(out_col_high)
    );

    function automatic int lane_out(int n);
        logic signed [OUT_W-1:0] v;
        v = out_data[n*OUT_W +: OUT_W];
        return int'(v);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string band_req(int rh, int ch);
        if (rh == 0 && ch == 0) return "R1";
        if (rh == 1 && ch == 1) return "R2";
        return "R3";
    endfunction

    // compare at negedge, then drive the next inputs
    task automatic step(input bit [LANES-1:0] v, input int d0, input int d1,
                        input bit [1:0] t0, input bit [1:0] t1);
        int dv [LANES];
        bit [1:0] tg [LANES];
        dv[0] = d0; dv[1] = d1; tg[0] = t0; tg[1] = t1;
        @(negedge clk);
        for (int n = 0; n < LANES; n++) begin
            check(int'(out_valid[n]) == exp_valid[n], "R4 valid", int'(out_valid[n]), exp_valid[n]);
            check(lane_out(n) == exp_data[n], exp_valid[n] ? band_req(exp_rh[n], exp_ch[n]) : "R10",
                  lane_out(n), exp_data[n]);
            check(int'(out_row_high[n]) == exp_rh[n] && int'(out_col_high[n]) == exp_ch[n],
                  "R5 tags", {out_row_high[n], out_col_high[n]}, exp_rh[n]*2 + exp_ch[n]);
            if (exp_valid[n] != 0 && exp_rh[n] == exp_ch[n]) begin
                real diff;
                diff = real'(lane_out(n)) - sep_ref[n];
                if (diff < 0.0) diff = -diff;
                check(diff <= 1.0, "R9 vs separate scaling", lane_out(n), int'($floor(sep_ref[n] + 0.5)));
            end
        end
        // model next expected
        for (int n = 0; n < LANES; n++) begin
            exp_valid[n] = v[n];
            if (v[n]) begin
                real g;
                exp_rh[n] = tg[n][1];
                exp_ch[n] = tg[n][0];
                if (tg[n] == 2'b00)      g = 21653.0 / 16384.0;
                else if (tg[n] == 2'b11) g = 12397.0 / 16384.0;
                else                     g = 1.0;
                exp_data[n] = int'($floor(real'(dv[n]) * g + 0.5));
                sep_ref[n] = real'(dv[n]) * (tg[n][1] ? 1.0/K_REAL : K_REAL)
                                          * (tg[n][0] ? 1.0/K_REAL : K_REAL);
            end
            in_data[n*DATA_W +: DATA_W] = DATA_W'(dv[n]);
            in_row_high[n] = tg[n][1];
            in_col_high[n] = tg[n][0];
        end
        in_valid = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        for (int n = 0; n < LANES; n++) begin
            check(out_valid[n] == 1'b0 && lane_out(n) == 0 && out_row_high[n] == 1'b0
                  && out_col_high[n] == 1'b0, "R7 reset", lane_out(n), 0);
            exp_valid[n] = 0; exp_data[n] = 0; exp_rh[n] = 0; exp_ch[n] = 0; sep_ref[n] = 0.0;
        end
        rst_n = 1'b1;
        // R1, R2, R3 on both lanes with distinct tags (R6)
        step(2'b11, 1000, -1000, 2'b00, 2'b11);
        step(2'b11, 1234, -4321, 2'b01, 2'b10);
        step(2'b11, -777, 555, 2'b11, 2'b00);
        // extremes
        step(2'b11, 32767, -32768, 2'b00, 2'b00);
        step(2'b11, -32768, 32767, 2'b11, 2'b11);
        step(2'b11, -32768, 32767, 2'b10, 2'b01);
        // R8 tie cases
        step(2'b11, 8192, -8192, 2'b00, 2'b00);
        // R10 idle on one lane, then both
        step(2'b01, 99, 12345, 2'b00, 2'b11);
        step(2'b00, 7, 7, 2'b11, 2'b11);
        step(2'b00, -7, -7, 2'b00, 2'b00);
        step(2'b10, 3, 4096, 2'b01, 2'b00);
        // sweep
        for (int i = 0; i < 400; i++) begin
            bit [1:0] v2;
            v2 = 2'($urandom_range(0, 3));
            step(v2, $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
                 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
        end
        step(2'b00, 0, 0, 2'b00, 2'b00);
        step(2'b00, 0, 0, 2'b00, 2'b00);
        // explicit R8 values after the tie step were covered by the model; direct check too
        step(2'b11, 8192, -8192, 2'b00, 2'b00);
        @(negedge clk);
        check(lane_out(0) == 10827, "R8 half up positive", lane_out(0), 10827);
        check(lane_out(1) == -10826, "R8 half up negative", lane_out(1), -10826);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                fails++;
                tests++;
                $display("FAIL watchdog: actual 0 expected 1");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule